// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block walks a chain of 16-byte transfer descriptors kept in memory and hands each buffer to a data mover. Software writes a start pointer and pulses a start command. The engine then fetches the descriptor at that pointer one 32-bit word at a time, in four reads. It checks that hardware owns the descriptor and that its byte checksum is valid. If both hold, it either skips the descriptor or passes its buffer address and length to the mover. When the transfer is done, it writes the first descriptor word back and moves on to the next-descriptor link.

The engine stays active when it meets a descriptor that software still owns, a bad checksum or a zero length. It then waits for a resume command, which makes it fetch the same descriptor again. A stop command ends the run. The current-pointer output always shows the descriptor now being handled, so software can retire every descriptor before it. A one-cycle pulse marks each completion that asked for notification, each checksum failure and each length failure.

Top module: `desc_ring_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `q_active`, `mem_req`, `mv_req` and all three pulses are 0, and `cur_ptr` is 0.
- R2: A start command given while the queue is inactive loads `cur_ptr` from `start_addr` and raises `q_active`. It then reads the four descriptor words at `cur_ptr`, `cur_ptr`+4, +8 and +12, in that order. A start command given while the queue is active has no effect.
- R3: Descriptor layout:
  - word 0: bits [7:0] are flags (bit 0 = hardware owned, bit 2 = skip, bit 7 = notify on completion), bits [15:8] are the check byte, bits [31:16] are the length.
  - word 1: buffer address.
  - word 2: next-descriptor address.
  - word 3: bits [7:0] are extension flags (bit 5 = zero-length-packet request, carried unchanged); the rest is reserved.
  - A descriptor is valid when the sum of all 16 bytes, modulo 256, equals 0xFF.
- R4: A descriptor with flag bit 0 clear causes no mover request, no write and no pulse. The queue stays active and waits. A resume command then fetches the same descriptor again (four more reads).
- R5: An owned descriptor with a bad check byte causes one `csum_err_pulse`. The descriptor is left unmodified in memory, `cur_ptr` is kept, and the engine waits for resume.
- R6: An owned, valid, non-skipped descriptor with length 0 causes one `len_err_pulse` and no mover request. `cur_ptr` is kept and the engine waits for resume.
- R7: Otherwise, the engine holds `mv_req` with the buffer address and length until `mv_ack`. It then writes word 0 back with bit 0 cleared, the length field set to `mv_actual`, and every other bit unchanged. After that write is acknowledged, it sets `cur_ptr` to the next link. In the same cycle that `cur_ptr` changes, it pulses `done_pulse` if flag bit 7 is set.
- R8: An owned, valid descriptor with flag bit 2 set moves no data, even if its length is 0. Its word 0 is written back with bit 0 cleared and length 0. The engine then follows the next link, and a done pulse follows the rule of R7.
- R9: A stop command in the waiting state clears `q_active` at the next clock edge. A stop command at any other active time clears it once the current descriptor step ends, after which no memory request is made. A resume command while inactive has no effect.
- R10: Once raised, `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. Only one memory access is outstanding at a time.
- R11: The three pulses never occur together and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| start_addr | input | ADDR_W | Byte address of the first descriptor |
| q_active | output | 1 | Queue running status |
| cur_ptr | output | ADDR_W | Address of the descriptor being handled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | ADDR_W | Buffer address for the mover |
| mv_len | output | 16 | Buffer length for the mover |
| mv_ack | input | 1 | Mover finished |
| mv_actual | input | 16 | Bytes actually moved |
| done_pulse | output | 1 | Notified completion |
| len_err_pulse | output | 1 | Zero-length failure |
| csum_err_pulse | output | 1 | Checksum failure |

## Verification
Error pulses appear two edges after the acknowledge of the fourth descriptor read: one edge to evaluate, one to register the pulse. A done pulse appears one edge after the write-back acknowledge, together with the new `cur_ptr`. A stop command given while waiting takes effect at the very next edge. The bench checks the stop result one time unit after that edge. For everything else, the bench waits until the memory and mover ports have been quiet for eight cycles. It then compares the descriptor words, the pointer and event counters against values computed from the requirements. Because of this, mover and memory latency never shift a sample point.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int DESC_WORDS = 4;
  localparam int WORD_W     = 32;
  localparam int FLAG_OWN   = 0;
  localparam int FLAG_SKIP  = 2;
  localparam int FLAG_NOTE  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EVAL, ST_MOVE, ST_WB, ST_HOLD
  } eng_state_t;

  // modulo-256 sum of the four bytes of one word
  function automatic logic [7:0] word_byte_sum(input logic [WORD_W-1:0] w);
    logic [7:0] s;
    s = '0;
    for (int b = 0; b < WORD_W / 8; b++) s = s + w[8*b +: 8];
    return s;
  endfunction

  // word 0 after completion: ownership dropped, length replaced
  function automatic logic [WORD_W-1:0] retire_word(input logic [WORD_W-1:0] w0,
                                                    input logic [15:0] moved);
    return {moved, w0[15:8], w0[7:1], 1'b0};
  endfunction
endpackage

// File: rtl/dre_desc_store.sv
module dre_desc_store #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cap_en,
  input  logic [IDX_W-1:0]                   cap_idx,
  input  logic [WORD_W-1:0]                  cap_data,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   words
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (cap_en && cap_idx == IDX_W'(g))     q <= cap_data;
    end
    assign words[g] = q;
  end
endmodule

// File: rtl/dre_csum_check.sv
module dre_csum_check
  import dre_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
  output logic                             sum_ok
);
  logic [7:0] acc;
  always_comb begin
    acc = '0;
    for (int w = 0; w < NUM_WORDS; w++) acc = acc + word_byte_sum(words[w]);
    sum_ok = (acc == 8'hFF);
  end
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import dre_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STOP_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_resume,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              q_active,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              mv_req,
  output logic [ADDR_W-1:0] mv_addr,
  output logic [15:0]       mv_len,
  input  logic              mv_ack,
  input  logic [15:0]       mv_actual,
  output logic              done_pulse,
  output logic              len_err_pulse,
  output logic              csum_err_pulse
);
  localparam int IDX_W    = $clog2(DESC_WORDS);
  localparam int STOP_CW  = $clog2(STOP_LIMIT + 1) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  eng_state_t                         state;
  logic [IDX_W-1:0]                   widx;
  logic [ADDR_W-1:0]                  cur_q;
  logic [15:0]                        moved_q;
  logic                               stop_pend;
  logic                               done_q, lerr_q, cerr_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0]  dwords;
  logic                               sum_ok;

  // named internal events
  logic cap_en, in_hold, rd_last, wb_ack, stop_now;
  logic [7:0] dflags;
  assign cap_en   = (state == ST_READ) && mem_ack;
  assign rd_last  = cap_en && (widx == LAST_IDX);
  assign wb_ack   = (state == ST_WB) && mem_ack;
  assign in_hold  = (state == ST_HOLD);
  assign stop_now = stop_pend || cmd_stop;
  assign dflags   = dwords[0][7:0];

  dre_desc_store #(.WORD_W(WORD_W), .NUM_WORDS(DESC_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(widx),
    .cap_data(mem_rdata), .words(dwords)
  );

  dre_csum_check #(.NUM_WORDS(DESC_WORDS)) u_csum (
    .words(dwords), .sum_ok(sum_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      widx      <= '0;
      cur_q     <= '0;
      moved_q   <= '0;
      stop_pend <= 1'b0;
      done_q    <= 1'b0;
      lerr_q    <= 1'b0;
      cerr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      lerr_q <= 1'b0;
      cerr_q <= 1'b0;
      if (cmd_stop && state != ST_IDLE) stop_pend <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            cur_q <= start_addr;
            widx  <= '0;
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            widx <= widx + 1'b1;
            if (widx == LAST_IDX) state <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (stop_now) begin
            state <= ST_IDLE; stop_pend <= 1'b0;
          end else if (!dflags[FLAG_OWN]) begin
            state <= ST_HOLD;
          end else if (!sum_ok) begin
            cerr_q <= 1'b1; state <= ST_HOLD;
          end else if (dflags[FLAG_SKIP]) begin
            moved_q <= '0; state <= ST_WB;
          end else if (dwords[0][31:16] == 16'd0) begin
            lerr_q <= 1'b1; state <= ST_HOLD;
          end else begin
            state <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (mv_ack) begin
            moved_q <= mv_actual;
            state   <= ST_WB;
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            cur_q  <= dwords[2][ADDR_W-1:0];
            done_q <= dflags[FLAG_NOTE];
            widx   <= '0;
            if (stop_now) begin
              state <= ST_IDLE; stop_pend <= 1'b0;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_HOLD: begin
          if (stop_now) begin
            state <= ST_IDLE; stop_pend <= 1'b0;
          end else if (cmd_resume) begin
            widx  <= '0;
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign q_active       = (state != ST_IDLE);
  assign cur_ptr        = cur_q;
  assign mem_req        = (state == ST_READ) || (state == ST_WB);
  assign mem_we         = (state == ST_WB);
  assign mem_addr       = (state == ST_READ) ? cur_q + ADDR_W'({widx, 2'b00}) : cur_q;
  assign mem_wdata      = retire_word(dwords[0], moved_q);
  assign mv_req         = (state == ST_MOVE);
  assign mv_addr        = dwords[1][ADDR_W-1:0];
  assign mv_len         = dwords[0][31:16];
  assign done_pulse     = done_q;
  assign len_err_pulse  = lerr_q;
  assign csum_err_pulse = cerr_q;

  // ---------------- assertions ----------------
  // R10: memory request held stable until acknowledged
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R7: mover request held stable until acknowledged
  a_r7_mv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_ack |=> mv_req && $stable(mv_addr) && $stable(mv_len));

  // R7: pointer advances only right after an acknowledged write-back
  a_r7_wb_before_adv: assert property (@(posedge clk) disable iff (!rst_n)
    q_active && $past(q_active) && (cur_ptr != $past(cur_ptr)) |-> $past(mem_ack && mem_we));

  // R11: pulses exclusive and one cycle long
  a_r11_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, len_err_pulse, csum_err_pulse}));
  a_r11_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || csum_err_pulse || len_err_pulse) |=> !(csum_err_pulse || len_err_pulse));

  // R5: checksum failure leaves memory alone and waits
  a_r5_csum_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err_pulse |-> in_hold && !mem_req && !mv_req);

  // R6: zero length never reaches the mover
  a_r6_len_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_pulse |-> in_hold && !mv_req);

  // R4: waiting without resume issues no traffic
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold && !cmd_resume |=> !mem_req && !mv_req);

  // R2: start while active leaves the pointer alone
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    q_active && cmd_start && !wb_ack |=> $stable(cur_ptr));

  // R9: stop while waiting drops active at the next edge
  a_r9_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold && cmd_stop |=> !q_active);

  // R9: a stop request is honoured within STOP_LIMIT cycles
  logic               stop_seen;
  logic [STOP_CW-1:0] stop_age;
  always_ff @(posedge clk) begin
    if (!rst_n || !q_active) begin
      stop_seen <= 1'b0;
      stop_age  <= '0;
    end else begin
      if (cmd_stop) stop_seen <= 1'b1;
      if (stop_seen) stop_age <= stop_age + 1'b1;
    end
  end
  a_r9_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stop_age < STOP_CW'(STOP_LIMIT));

  // R1: idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(!rst_n) |-> !q_active && !mem_req && !mv_req && !done_pulse);

  // R3: ownership gates every transfer
  a_r3_own_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mv_req) |-> dflags[FLAG_OWN] && sum_ok);
endmodule

// File: tb/tb_desc_ring_engine.sv
`timescale 1ns/1ps
module tb_desc_ring_engine;
  localparam int AW = 32;

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic          cmd_start = 0, cmd_stop = 0, cmd_resume = 0;
  logic [AW-1:0] start_addr = '0;
  logic          q_active, mem_req, mem_we, mv_req;
  logic [AW-1:0] cur_ptr, mem_addr, mv_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          mem_ack, mv_ack;
  logic [15:0]   mv_len, mv_actual;
  logic          done_pulse, len_err_pulse, csum_err_pulse;

  desc_ring_engine #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_resume(cmd_resume), .start_addr(start_addr), .q_active(q_active),
    .cur_ptr(cur_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_ack(mv_ack),
    .mv_actual(mv_actual), .done_pulse(done_pulse),
    .len_err_pulse(len_err_pulse), .csum_err_pulse(csum_err_pulse)
  );

  // ---------------- memory and mover models ----------------
  logic [31:0] mem [0:255];
  logic        tb_wr_en = 0;
  logic [7:0]  tb_wr_idx = '0;
  logic [31:0] tb_wr_data = '0;
  logic [15:0] mv_cap = 16'hFFFF;
  int          mv_wait;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
    if (tb_wr_en) mem[tb_wr_idx] <= tb_wr_data;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mv_ack <= 0; mv_actual <= '0; mv_wait <= 2;
    end else if (mv_req && !mv_ack) begin
      if (mv_wait == 0) begin
        mv_ack    <= 1;
        mv_actual <= (mv_len < mv_cap) ? mv_len : mv_cap;
        mv_wait   <= int'($urandom % 4);
      end else mv_wait <= mv_wait - 1;
    end else mv_ack <= 0;
  end

  // ---------------- event monitor ----------------
  int n_done = 0, n_lerr = 0, n_cerr = 0, n_mv = 0, n_rd = 0, n_wr = 0;
  int log_cnt = 4;
  logic [AW-1:0] rd_log [0:3];
  always @(posedge clk) begin
    if (rst_n) begin
      if (done_pulse) n_done++;
      if (len_err_pulse) n_lerr++;
      if (csum_err_pulse) n_cerr++;
      if (mv_req && mv_ack) n_mv++;
      if (mem_req && mem_ack && !mem_we) begin
        n_rd++;
        if (log_cnt < 4) begin rd_log[log_cnt] = mem_addr; log_cnt++; end
      end
      if (mem_req && mem_ack && mem_we) n_wr++;
      if (cmd_start && !q_active) log_cnt = 0;
    end
  end

  // ---------------- checking ----------------
  int tests = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  // ---------------- bench functions ----------------
  function automatic logic [7:0] sum_bytes(input logic [31:0] w);
    return w[31:24] + w[23:16] + w[15:8] + w[7:0];
  endfunction

  function automatic logic [7:0] want_check(input logic [31:0] w0, w1, w2, w3);
    logic [7:0] s;
    s = sum_bytes({w0[31:16], 8'h00, w0[7:0]}) + sum_bytes(w1) + sum_bytes(w2) + sum_bytes(w3);
    return 8'hFF - s;
  endfunction

  function automatic logic [31:0] after_done(input logic [31:0] w0, input logic [15:0] n);
    return {n, w0[15:8], w0[7:0] & 8'hFE};
  endfunction

  logic [31:0] orig0 [0:63];

  task automatic mwrite(input int idx, input logic [31:0] d);
    tb_wr_en = 1; tb_wr_idx = 8'(idx); tb_wr_data = d;
    @(posedge clk); #1;
    tb_wr_en = 0;
  endtask

  task automatic put_desc(input int k, input logic [7:0] fl, input logic [15:0] len,
                          input int nk, input bit bad);
    logic [31:0] w0, w1, w2, w3;
    logic [7:0] cs;
    w1 = $urandom; w2 = 32'(nk * 16);
    w3 = {$urandom_range(255, 0) == 0 ? 24'h0 : 24'($urandom), 8'($urandom) | 8'h20};
    w0 = {len, 8'h00, fl};
    cs = want_check(w0, w1, w2, w3);
    if (bad) cs = cs ^ 8'h5A;
    w0[15:8] = cs;
    orig0[k] = w0;
    mwrite(4*k, w0); mwrite(4*k+1, w1); mwrite(4*k+2, w2); mwrite(4*k+3, w3);
  endtask

  task automatic pulse_start(input logic [AW-1:0] a);
    start_addr = a; cmd_start = 1; @(posedge clk); #1; cmd_start = 0;
  endtask
  task automatic pulse_stop();
    cmd_stop = 1; @(posedge clk); #1; cmd_stop = 0;
  endtask
  task automatic pulse_resume();
    cmd_resume = 1; @(posedge clk); #1; cmd_resume = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int t = 0;
    while (q < 8 && t < 5000) begin
      @(posedge clk); #1;
      if (!mem_req && !mv_req) q++; else q = 0;
      t++;
    end
  endtask

  // ---------------- stimulus ----------------
  int d0, m0, r0, w0c, c0, l0, e_done, e_mv;
  logic [15:0] lens [0:7];

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk); #1;
    chk("R1 active in reset", {31'd0, q_active}, 0);
    chk("R1 requests in reset", {30'd0, mem_req, mv_req}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 idle after reset", {28'd0, q_active, done_pulse, len_err_pulse, csum_err_pulse}, 0);
    chk("R1 pointer after reset", cur_ptr, 0);

    // directed ring 0..3, tail 4 software owned
    lens[0] = 5; lens[1] = 300; lens[2] = 1; lens[3] = 77;
    put_desc(0, 8'h81, lens[0], 1, 0);
    put_desc(1, 8'h01, lens[1], 2, 0);
    put_desc(2, 8'h81, lens[2], 3, 0);
    put_desc(3, 8'h81, lens[3], 4, 0);
    put_desc(4, 8'h00, 16'd9, 5, 0);
    mv_cap = 16'd200;
    d0 = n_done; m0 = n_mv;
    pulse_start(32'h0);
    chk("R2 active after start", {31'd0, q_active}, 1);
    wait_quiet();
    for (int i = 0; i < 4; i++) chk("R2 fetch order", rd_log[i], 32'(4*i));
    chk("R7 pointer at tail", cur_ptr, 32'd64);
    chk("R4 waits active on software owned", {31'd0, q_active}, 1);
    chk("R7 done count", 32'(n_done - d0), 3);
    chk("R7 mover count", 32'(n_mv - m0), 4);
    for (int k = 0; k < 4; k++)
      chk("R7 write-back word", mem[4*k],
          after_done(orig0[k], (lens[k] < mv_cap) ? lens[k] : mv_cap));
    chk("R3 link word untouched", mem[6], 32'd32);
    chk("R4 tail untouched", mem[16], orig0[4]);

    // start while active
    pulse_start(32'h100);
    repeat (4) @(posedge clk); #1;
    chk("R2 start ignored pointer", cur_ptr, 32'd64);
    chk("R2 start ignored traffic", {31'd0, mem_req}, 0);

    // resume on still software owned: refetch only
    r0 = n_rd; w0c = n_wr;
    pulse_resume(); wait_quiet();
    chk("R4 refetch reads", 32'(n_rd - r0), 4);
    chk("R4 refetch no write", 32'(n_wr - w0c), 0);
    chk("R4 refetch pointer", cur_ptr, 32'd64);

    // checksum failure
    put_desc(4, 8'h81, 16'd10, 5, 1);
    put_desc(5, 8'h00, 16'd0, 6, 0);
    c0 = n_cerr; m0 = n_mv; w0c = n_wr;
    pulse_resume(); wait_quiet();
    chk("R5 csum pulse", 32'(n_cerr - c0), 1);
    chk("R5 no write", 32'(n_wr - w0c), 0);
    chk("R5 no move", 32'(n_mv - m0), 0);
    chk("R5 pointer kept", cur_ptr, 32'd64);
    chk("R5 descriptor unmodified", mem[16], orig0[4]);
    put_desc(4, 8'h81, 16'd10, 5, 0);
    d0 = n_done;
    pulse_resume(); wait_quiet();
    chk("R4 resume continues", cur_ptr, 32'd80);
    chk("R7 done after fix", 32'(n_done - d0), 1);
    chk("R7 fixed write-back", mem[16], after_done(orig0[4], 16'd10));

    // zero length
    put_desc(5, 8'h01, 16'd0, 6, 0);
    put_desc(6, 8'h00, 16'd3, 7, 0);
    l0 = n_lerr; m0 = n_mv;
    pulse_resume(); wait_quiet();
    chk("R6 length pulse", 32'(n_lerr - l0), 1);
    chk("R6 no move", 32'(n_mv - m0), 0);
    chk("R6 pointer kept", cur_ptr, 32'd80);

    // bypass
    put_desc(5, 8'h85, 16'd40, 6, 0);
    d0 = n_done; m0 = n_mv;
    pulse_resume(); wait_quiet();
    chk("R8 skip pointer", cur_ptr, 32'd96);
    chk("R8 skip no move", 32'(n_mv - m0), 0);
    chk("R8 skip write-back", mem[20], after_done(orig0[5], 16'd0));
    chk("R8 skip done", 32'(n_done - d0), 1);

    // stop while waiting
    pulse_stop();
    chk("R9 stop drops active", {31'd0, q_active}, 0);
    r0 = n_rd;
    pulse_resume();
    repeat (6) @(posedge clk); #1;
    chk("R9 resume while idle", {30'd0, q_active, mem_req}, 0);
    chk("R9 no reads while idle", 32'(n_rd - r0), 0);

    // random rounds
    for (int rnd = 0; rnd < 8; rnd++) begin
      int base, n;
      logic [7:0] fl;
      base = 8 + int'($urandom % 40);
      n = 2 + int'($urandom % 5);
      mv_cap = 16'(1 + ($urandom % 1500));
      e_done = 0; e_mv = 0;
      for (int i = 0; i < n; i++) begin
        fl = 8'h01;
        if ($urandom % 4 == 0) fl = fl | 8'h04;
        if ($urandom % 2 == 0) fl = fl | 8'h80;
        lens[i] = (fl[2]) ? 16'($urandom % 50) : 16'(1 + ($urandom % 2000));
        if (fl[7]) e_done++;
        if (!fl[2]) e_mv++;
        put_desc(base + i, fl, lens[i], base + i + 1, 0);
      end
      put_desc(base + n, 8'h00, 16'd1, base + n + 1, 0);
      d0 = n_done; m0 = n_mv;
      pulse_start(32'(base * 16));
      wait_quiet();
      for (int i = 0; i < 4; i++) chk("R2 random fetch order", rd_log[i], 32'(base*16 + 4*i));
      chk("R7 random tail pointer", cur_ptr, 32'((base + n) * 16));
      chk("R7 random done count", 32'(n_done - d0), 32'(e_done));
      chk("R8 random move count", 32'(n_mv - m0), 32'(e_mv));
      for (int i = 0; i < n; i++)
        chk("R7 random write-back", mem[4*(base+i)],
            after_done(orig0[base+i], orig0[base+i][2] ? 16'd0 :
                       ((lens[i] < mv_cap) ? lens[i] : mv_cap)));
      pulse_stop();
      chk("R9 random stop", {31'd0, q_active}, 0);
    end

    // stop in mid-run
    for (int i = 0; i < 8; i++) put_desc(i, 8'h01, 16'd100, i + 1, 0);
    put_desc(8, 8'h00, 16'd0, 9, 0);
    mv_cap = 16'hFFFF;
    pulse_start(32'h0);
    repeat (20) @(posedge clk); #1;
    pulse_stop();
    begin
      int t = 0;
      while (q_active && t < 200) begin @(posedge clk); #1; t++; end
    end
    chk("R9 mid-run stop falls", {31'd0, q_active}, 0);
    r0 = n_rd; w0c = n_wr;
    repeat (10) @(posedge clk); #1;
    chk("R10 no traffic after stop", 32'((n_rd - r0) + (n_wr - w0c)), 0);

    finish_run();
  end
endmodule